// File: doc/BRIEF.md
# Oversampled Serial Receiver with Vote Sampling and Word Queue

This block is the receive half of an asynchronous serial port. It watches a single serial input and a one-cycle enable that pulses sixteen times per bit period. Once a start bit is found, it decides each bit from three samples taken around the middle of the bit. It collects seven or eight data bits and an optional ninth bit, checks the first stop bit, and queues each good character together with its ninth bit.

A second line mode accepts infrared-style coding. In that mode a zero is a short low pulse and a one is no pulse. A pulse that lasts a single sample is discarded as noise. A low-power state flushes the receiver and raises a sticky flag on any edge seen on the line. The host side is reduced to a pop strobe, which reads the oldest word, and a clear strobe, which empties the queue and drops the framing-error flag.

Top module: `rxv_top`

## Requirements
- R1: A character starts only on a tick where the synchronized line is low and the line at the previous tick was high. A line that stays low starts nothing more.
- R2: Counting the start tick as sample 1, every bit takes the 2-of-3 majority of its samples 7, 8 and 9. Samples 1 to 6 and 10 to 16 have no effect on the bit.
- R3: If the vote on the start bit gives 1, the receiver goes back to hunting for a start and stores nothing.
- R4: If the first stop bit votes 0, `frame_err` is set, nothing is stored and hunting resumes. `frame_err` is not stored in the queue. A pop does not change it, and it clears on the next character that ends with a good stop bit.
- R5: Data bits arrive LSB first. When `cfg_len7`=1 there are seven data bits and `rd_data[7]` reads 0. When `cfg_par_en`=1, the bit after the data is kept as `rd_ninth`; otherwise `rd_ninth` reads 0.
- R6: The queue holds FIFO_DEPTH (8) words and returns them oldest first. `rdy` is 1 while a word is held. A `pop` removes the oldest word. With the queue empty, `rd_data` and `rd_ninth` read 0.
- R7: A word that arrives while the queue is full, with no pop in the same cycle, empties the whole queue. That word is dropped too.
- R8: When `cfg_fifo_off`=1 the queue acts as a single register. A new word replaces the held one, and one pop empties it.
- R9: When `cfg_irda`=1, a low pulse marks a 0 bit. Each bit is sampled once, on the second tick of its window, and a pulse is counted only if it was low on two consecutive ticks. A one-tick pulse reads as 1.
- R10: While `shutdown`=1 the receiver is idle, the queue is empty and `frame_err` is 0. Any edge on the line sets `rx_activity`, which then stays set. Leaving shutdown clears it on the next clock.
- R11: A `clr` pulse empties the queue and clears `frame_err` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-cycle enable, sixteen per bit period |
| cfg_len7 | input | 1 | 1 selects seven data bits |
| cfg_par_en | input | 1 | 1 expects a ninth bit after the data |
| cfg_irda | input | 1 | 1 selects pulse-coded line decoding |
| cfg_fifo_off | input | 1 | 1 makes the queue a single register |
| shutdown | input | 1 | Low-power state: flush and watch for activity |
| pop | input | 1 | Remove the oldest word |
| clr | input | 1 | Empty the queue and clear the framing error |
| rdy | output | 1 | A word is available |
| rd_data | output | 8 | Oldest data word, zero when empty |
| rd_ninth | output | 1 | Ninth bit of the oldest word, zero when empty |
| frame_err | output | 1 | Last character had a bad stop bit |
| rx_activity | output | 1 | Line edge seen during shutdown |

## Verification
A level on `rx_in` is used two clocks later, after two synchronizer flops. A stored word shows on `rdy`/`rd_data` one clock after the tick that carries sample 9 of the stop bit, or sample 2 in pulse mode. `pop`, `clr` and leaving shutdown take effect one clock after the strobe. `rx_activity` rises three clocks after a line edge. The bench drives each line level for a four-clock slot and puts the tick on the last clock of the slot, so the synchronized value is already settled when it is sampled. It checks received words only after the whole frame and two idle slots have been sent, and it checks strobe effects at the negedge after the strobe's clock edge.

// File: rtl/rxv_pkg.sv
package rxv_pkg;
  typedef enum logic {RX_HUNT, RX_SHIFT} rx_state_t;

  typedef struct packed {
    logic       ninth;
    logic [7:0] data;
  } rx_word_t;

  // phase (0-based, within a 16-tick bit window) where a bit is decided
  localparam logic [3:0] UART_DECIDE_PH = 4'd8;
  localparam logic [3:0] IRDA_DECIDE_PH = 4'd1;
endpackage

// File: rtl/rxv_sync.sv
module rxv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain, chain_n;

  always_comb chain_n = {chain[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= chain_n;
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxv_framer.sv
module rxv_framer import rxv_pkg::*; (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     line,
  input  logic     len7,
  input  logic     par_en,
  input  logic     irda,
  input  logic     hold,
  output logic     push,
  output logic     fe_set,
  output rx_word_t word
);
  rx_state_t  st, st_n;
  logic [3:0] ph, ph_n, bi, bi_n;
  logic       h1, h1_n, h2, h2_n;
  logic [7:0] sh, sh_n;
  logic       par, par_n;
  logic [3:0] stop_idx, data_top, dec_ph;
  logic       vote, decide, at_stop, start_hit;

  always_comb begin
    data_top  = len7 ? 4'd7 : 4'd8;
    stop_idx  = data_top + 4'd1 + {3'b000, par_en};
    dec_ph    = irda ? IRDA_DECIDE_PH : UART_DECIDE_PH;
    // h2/h1/line are the samples of the last three ticks
    vote      = irda ? (h1 | line) : ((h1 & h2) | (h1 & line) | (h2 & line));
    decide    = tick && (st == RX_SHIFT) && (ph == dec_ph);
    at_stop   = (bi == stop_idx);
    start_hit = tick && (st == RX_HUNT) && !line && (irda ? (!h1 && h2) : h1);
    push      = decide && at_stop && vote && !hold;
    fe_set    = decide && at_stop && !vote && !hold;

    st_n = st; ph_n = ph; bi_n = bi; sh_n = sh; par_n = par;
    h1_n = h1; h2_n = h2;
    if (tick) begin
      h1_n = line;
      h2_n = h1;
    end
    if (hold) begin
      st_n = RX_HUNT;
      h1_n = 1'b1;
      h2_n = 1'b1;
    end else if (start_hit) begin
      st_n  = RX_SHIFT;
      ph_n  = irda ? 4'd2 : 4'd1;   // pulse mode has already judged the start
      bi_n  = irda ? 4'd1 : 4'd0;
      sh_n  = '0;
      par_n = 1'b0;
    end else if (tick && st == RX_SHIFT) begin
      ph_n = ph + 4'd1;
      if (decide) begin
        if ((bi == 4'd0 && vote) || at_stop) begin
          st_n = RX_HUNT;
        end else begin
          if (bi != 4'd0) begin
            if (bi <= data_top) sh_n[3'(bi - 4'd1)] = vote;
            else                par_n = vote;
          end
          bi_n = bi + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_HUNT; ph <= '0; bi <= '0; sh <= '0; par <= 1'b0;
      h1 <= 1'b1; h2 <= 1'b1;
    end else begin
      st <= st_n; ph <= ph_n; bi <= bi_n; sh <= sh_n; par <= par_n;
      h1 <= h1_n; h2 <= h2_n;
    end
  end

  always_comb begin
    word.data  = len7 ? {1'b0, sh[6:0]} : sh;
    word.ninth = par_en & par;
  end
endmodule

// File: rtl/rxv_fifo.sv
module rxv_fifo import rxv_pkg::*; #(
  parameter int DEPTH = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flush,
  input  logic     bypass,
  input  logic     push,
  input  rx_word_t wdata,
  input  logic     pop,
  output logic     rdy,
  output logic     full,
  output rx_word_t rdata
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] ONE = AW'(1);

  rx_word_t      mem [DEPTH];
  logic [AW-1:0] rp, rp_n, wp, wp_n, waddr;
  logic [CW-1:0] cnt, cnt_n;
  logic          we, take;

  always_comb begin
    take  = pop && (cnt != '0);
    rp_n  = rp;
    wp_n  = wp;
    cnt_n = cnt;
    we    = 1'b0;
    waddr = wp;
    if (flush) begin
      rp_n = '0; wp_n = '0; cnt_n = '0;
    end else if (bypass) begin
      if (push) begin
        we = 1'b1; waddr = rp; cnt_n = CW'(1); wp_n = rp + ONE;
      end else if (take) begin
        rp_n = rp + ONE; wp_n = rp + ONE; cnt_n = '0;
      end
    end else if (push && full && !take) begin
      rp_n = '0; wp_n = '0; cnt_n = '0;   // overflow drops everything
    end else begin
      if (push) begin
        we   = 1'b1;
        wp_n = wp + ONE;
      end
      if (take) rp_n = rp + ONE;
      cnt_n = cnt + CW'(push) - CW'(take);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; cnt <= '0;
    end else begin
      rp <= rp_n; wp <= wp_n; cnt <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdy   = (cnt != '0);
  assign full  = (cnt == FULL_CNT);
  assign rdata = rdy ? mem[rp] : '0;
endmodule

// File: rtl/rxv_top.sv
module rxv_top import rxv_pkg::*; #(
  parameter int FIFO_DEPTH  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       tick16,
  input  logic       cfg_len7,
  input  logic       cfg_par_en,
  input  logic       cfg_irda,
  input  logic       cfg_fifo_off,
  input  logic       shutdown,
  input  logic       pop,
  input  logic       clr,
  output logic       rdy,
  output logic [7:0] rd_data,
  output logic       rd_ninth,
  output logic       frame_err,
  output logic       rx_activity
);
  logic [1:0] rst_pipe;
  logic       rst_q;
  logic       line, line_d;
  logic       fr_push, fr_fe, ff_full;
  rx_word_t   fr_word, ff_rdata;
  logic       fe_q, fe_n, ra_q, ra_n;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  rxv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_q), .d(rx_in), .q(line)
  );

  rxv_framer u_framer (
    .clk(clk), .rst_n(rst_q), .tick(tick16), .line(line),
    .len7(cfg_len7), .par_en(cfg_par_en), .irda(cfg_irda), .hold(shutdown),
    .push(fr_push), .fe_set(fr_fe), .word(fr_word)
  );

  rxv_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_q), .flush(shutdown | clr), .bypass(cfg_fifo_off),
    .push(fr_push), .wdata(fr_word), .pop(pop),
    .rdy(rdy), .full(ff_full), .rdata(ff_rdata)
  );

  always_comb begin
    fe_n = fe_q;
    if (shutdown || clr) fe_n = 1'b0;
    else if (fr_fe)      fe_n = 1'b1;
    else if (fr_push)    fe_n = 1'b0;
    ra_n = shutdown && (ra_q || (line != line_d));
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      fe_q <= 1'b0; ra_q <= 1'b0; line_d <= 1'b1;
    end else begin
      fe_q <= fe_n; ra_q <= ra_n; line_d <= line;
    end
  end

  assign rd_data     = ff_rdata.data;
  assign rd_ninth    = ff_rdata.ninth;
  assign frame_err   = fe_q;
  assign rx_activity = ra_q;
endmodule

// File: rtl/rxv_chk.sv
module rxv_chk (
  input logic clk,
  input logic rst_n,
  input logic shutdown,
  input logic clr,
  input logic pop,
  input logic cfg_fifo_off,
  input logic push,
  input logic full,
  input logic rdy,
  input logic frame_err,
  input logic rx_activity
);
  assert_good_frame_clears_fe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !frame_err);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !cfg_fifo_off) |=> !rdy);

  assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !shutdown && !clr && (cfg_fifo_off || !full || pop)) |=> rdy);

  assert_sleep_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> (!rdy && !frame_err));

  assert_activity_only_asleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown |=> !rx_activity);

  assert_activity_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown && rx_activity) |=> rx_activity);

  assert_clear_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!rdy && !frame_err));
endmodule

bind rxv_top rxv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .clr(clr), .pop(pop),
  .cfg_fifo_off(cfg_fifo_off), .push(fr_push), .full(ff_full),
  .rdy(rdy), .frame_err(frame_err), .rx_activity(rx_activity)
);

// File: tb/sim_rxv_top.sv
module sim_rxv_top;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n, rx, tick, len7, pe, irda, foff, sd, pop, clr;
  logic rdy, ninth, fe, ra;
  logic [7:0] data;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  rxv_top u0 (
    .clk(clk), .rst_n(rst_n), .rx_in(rx), .tick16(tick), .cfg_len7(len7),
    .cfg_par_en(pe), .cfg_irda(irda), .cfg_fifo_off(foff), .shutdown(sd),
    .pop(pop), .clr(clr), .rdy(rdy), .rd_data(data), .rd_ninth(ninth),
    .frame_err(fe), .rx_activity(ra)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_word(input string req, input logic er, input logic eb, input logic [7:0] ed);
    chk(req, {6'b0, rdy, ninth, data}, {6'b0, er, eb, ed});
  endtask

  // one tick slot: level held four clocks, tick on the last
  task automatic slot(input logic v);
    rx = v;
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n, input logic v);
    for (int i = 0; i < n; i++) slot(v);
  endtask

  function automatic logic fbit(input logic [7:0] d, input int nd, input logic p_en,
                                input logic p, input logic stopv, input int k);
    if (k == 0) return 1'b0;
    if (k <= nd) return d[k-1];
    if (p_en && k == nd + 1) return p;
    return stopv;
  endfunction

  function automatic logic [7:0] fmt(input logic [7:0] d, input logic l7);
    return l7 ? {1'b0, d[6:0]} : d;
  endfunction

  task automatic send_uart(input logic [7:0] d, input logic p, input logic stopv,
                           input int fb, input logic [15:0] fm);
    int nd;
    int nb;
    nd = len7 ? 7 : 8;
    nb = nd + int'(pe) + 2;
    idle(2, 1'b1);
    for (int k = 0; k < nb; k++) begin
      for (int i = 0; i < 16; i++)
        slot(fbit(d, nd, pe, p, stopv, k) ^ ((k == fb) ? fm[i] : 1'b0));
    end
    if (stopv) idle(2, 1'b1);
  endtask

  task automatic send_irda(input logic [7:0] d, input logic p, input logic stopv,
                           input logic glitch);
    int nd;
    int nb;
    nd = len7 ? 7 : 8;
    nb = nd + int'(pe) + 2;
    idle(3, 1'b1);
    for (int k = 0; k < nb; k++) begin
      if (!fbit(d, nd, pe, p, stopv, k)) begin
        idle(3, 1'b0);
        idle(13, 1'b1);
      end else if (glitch && k > 0 && k <= nd) begin
        slot(1'b0);
        idle(15, 1'b1);
      end else begin
        idle(16, 1'b1);
      end
    end
    idle(2, 1'b1);
  endtask

  task automatic do_pop();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] masks [7];
    logic [7:0] d, e;
    masks = '{16'h0040, 16'h0080, 16'h0100, 16'h00C0, 16'h0180, 16'h0140, 16'h0220};
    rx = 1; tick = 0; len7 = 0; pe = 0; irda = 0; foff = 0; sd = 0; pop = 0; clr = 0;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    chk_word("R6 reset empty", 1'b0, 1'b0, 8'h00);
    chk("R4 reset no framing error", {15'b0, fe}, 16'h0);
    chk("R10 reset no activity", {15'b0, ra}, 16'h0);

    // R5 format sweep over word length and ninth bit
    for (int c = 0; c < 4; c++) begin
      len7 = c[0];
      pe = c[1];
      for (int i = 0; i < 16; i++) begin
        d = 8'(i * 73 + c * 29 + 5);
        send_uart(d, i[0] ^ c[0], 1'b1, -1, 16'h0);
        chk_word("R5 received word", 1'b1, pe & (i[0] ^ c[0]), fmt(d, len7));
        do_pop();
        chk_word("R6 empty after pop", 1'b0, 1'b0, 8'h00);
      end
    end
    len7 = 0;
    pe = 0;

    // R2 vote window: corrupt data bit index 3 (d[2]) at chosen samples
    for (int m = 0; m < 7; m++) begin
      send_uart(8'hA5, 1'b0, 1'b1, 3, masks[m]);
      e = ($countones(masks[m] & 16'h01C0) >= 2) ? 8'hA1 : 8'hA5;
      chk_word("R2 majority of samples 7-9", 1'b1, 1'b0, e);
      do_pop();
    end
    send_uart(8'h5C, 1'b0, 1'b1, 0, 16'h0080);
    chk_word("R2 start bit single outlier", 1'b1, 1'b0, 8'h5C);
    do_pop();

    // R3 false start
    idle(4, 1'b1);
    idle(5, 1'b0);
    idle(30, 1'b1);
    chk_word("R3 false start stores nothing", 1'b0, 1'b0, 8'h00);
    chk("R3 false start no framing error", {15'b0, fe}, 16'h0);
    send_uart(8'h3E, 1'b0, 1'b1, -1, 16'h0);
    chk_word("R3 recovers after false start", 1'b1, 1'b0, 8'h3E);
    do_pop();

    // R4 and R1: bad stop bit, line held low afterwards
    send_uart(8'h11, 1'b0, 1'b1, -1, 16'h0);
    send_uart(8'h3C, 1'b0, 1'b0, -1, 16'h0);
    idle(40, 1'b0);
    idle(5, 1'b1);
    chk("R4 bad stop sets error", {15'b0, fe}, 16'h1);
    chk_word("R4 bad frame not stored, R1 no restart on held low", 1'b1, 1'b0, 8'h11);
    do_pop();
    chk("R4 pop keeps error", {15'b0, fe}, 16'h1);
    chk_word("R4 queue empty", 1'b0, 1'b0, 8'h00);
    send_uart(8'h5A, 1'b0, 1'b1, -1, 16'h0);
    chk("R4 good frame clears error", {15'b0, fe}, 16'h0);
    chk_word("R4 good frame stored", 1'b1, 1'b0, 8'h5A);
    do_pop();

    // R6 order through a full queue
    for (int k = 0; k < 8; k++) send_uart(8'(8'h80 + k * 3), 1'b0, 1'b1, -1, 16'h0);
    for (int k = 0; k < 8; k++) begin
      chk_word("R6 oldest first", 1'b1, 1'b0, 8'(8'h80 + k * 3));
      do_pop();
    end
    chk_word("R6 empty reads zero", 1'b0, 1'b0, 8'h00);

    // R7 overflow
    for (int k = 0; k < 9; k++) send_uart(8'(k * 5 + 1), 1'b0, 1'b1, -1, 16'h0);
    chk_word("R7 overflow empties queue", 1'b0, 1'b0, 8'h00);
    send_uart(8'h99, 1'b0, 1'b1, -1, 16'h0);
    chk_word("R7 fresh word after overflow", 1'b1, 1'b0, 8'h99);
    do_pop();
    chk_word("R7 single entry after overflow", 1'b0, 1'b0, 8'h00);

    // R8 single register mode
    foff = 1;
    send_uart(8'h21, 1'b0, 1'b1, -1, 16'h0);
    send_uart(8'h42, 1'b0, 1'b1, -1, 16'h0);
    chk_word("R8 newest replaces held word", 1'b1, 1'b0, 8'h42);
    do_pop();
    chk_word("R8 one pop empties", 1'b0, 1'b0, 8'h00);
    foff = 0;

    // R9 pulse-coded line
    irda = 1;
    for (int i = 0; i < 8; i++) begin
      len7 = i[0];
      pe = i[1];
      d = 8'(i * 53 + 17);
      send_irda(d, i[2], 1'b1, i[0]);
      chk_word("R9 pulse-coded word", 1'b1, pe & i[2], fmt(d, len7));
      do_pop();
    end
    len7 = 0;
    pe = 0;
    send_irda(8'h0F, 1'b0, 1'b0, 1'b0);
    chk("R9 pulse in stop bit is framing error", {15'b0, fe}, 16'h1);
    chk_word("R9 bad frame not stored", 1'b0, 1'b0, 8'h00);
    send_irda(8'hC3, 1'b0, 1'b1, 1'b1);
    chk("R9 good frame clears error", {15'b0, fe}, 16'h0);
    chk_word("R9 glitches ignored", 1'b1, 1'b0, 8'hC3);
    do_pop();
    irda = 0;

    // R11 clear strobe
    send_uart(8'h66, 1'b0, 1'b1, -1, 16'h0);
    send_uart(8'h00, 1'b0, 1'b0, -1, 16'h0);
    idle(20, 1'b0);
    idle(3, 1'b1);
    chk("R11 error present before clear", {15'b0, fe}, 16'h1);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk_word("R11 clear empties queue", 1'b0, 1'b0, 8'h00);
    chk("R11 clear drops error", {15'b0, fe}, 16'h0);

    // R10 shutdown
    send_uart(8'h44, 1'b0, 1'b1, -1, 16'h0);
    sd = 1'b1;
    repeat (2) @(negedge clk);
    chk_word("R10 shutdown flushes", 1'b0, 1'b0, 8'h00);
    chk("R10 no activity yet", {15'b0, ra}, 16'h0);
    rx = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 edge sets activity", {15'b0, ra}, 16'h1);
    rx = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 activity sticky", {15'b0, ra}, 16'h1);
    send_uart(8'h77, 1'b0, 1'b1, -1, 16'h0);
    chk_word("R10 no reception in shutdown", 1'b0, 1'b0, 8'h00);
    sd = 1'b0;
    @(negedge clk);
    chk("R10 wake clears activity", {15'b0, ra}, 16'h0);
    send_uart(8'h29, 1'b0, 1'b1, -1, 16'h0);
    chk_word("R10 reception after wake", 1'b1, 1'b0, 8'h29);
    do_pop();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule